// File: doc/BRIEF.md
# Branch Direction and Return Address Predictor

This block sits in an instruction fetch front end and answers two questions about the instruction being fetched. For a conditional branch it predicts the direction from a table of two-bit saturating counters. The table is indexed by a slice of the fetch PC and is shared by every hardware thread. For a subroutine return it supplies a predicted target from a small return-address stack. Each thread owns its own stack.

The lookup port carries a PC, a thread id and a two-bit instruction class. For a call, the stack of the issuing thread captures the address of the instruction after the delay slot. For a return, that stack supplies its newest entry and drops it. Branch resolution reports the actual outcome of each conditional branch on a separate update port. The update is applied to the counter with a read-modify-write. Both lookup results are combinational in the cycle of the lookup. Stack and counter changes take effect at the following clock edge.

Top module: `bpred_top`

## Requirements
- R1: After reset every counter holds weakly not-taken (01). A conditional lookup then predicts not-taken, and a single taken update makes the same entry predict taken.
- R2: `pred_taken` is the MSB of the selected counter. It is asserted only for a valid lookup of class conditional (`lk_class` = 1). A taken update increments the counter and a not-taken update decrements it.
- R3: Counters saturate at 3 and at 0. After many taken updates, one not-taken update still leaves a taken prediction. After many not-taken updates, one taken update still leaves a not-taken prediction.
- R4: The counter is selected by PC bits [11:3]. PCs that differ only outside those bits share a counter. PCs that differ inside them use separate counters.
- R5: When an update and a lookup select the same counter in the same cycle, the lookup sees the value as modified by that update.
- R6: The direction table is common to all threads, so the thread id has no effect on `pred_taken`.
- R7: A valid lookup of class call (`lk_class` = 2) pushes PC + 8 onto the issuing thread's stack. A valid lookup of class return (`lk_class` = 3) raises `ret_valid`, shows the newest entry on `ret_target` and pops it.
- R8: The stack is last-in first-out over up to four entries.
- R9: A push onto a full stack overwrites the oldest entry. After five pushes, four pops return the last four addresses newest first and a fifth pop is invalid.
- R10: A return lookup on an empty stack gives `ret_valid` = 0 and leaves the stack empty.
- R11: Each thread's stack is independent: pushes and pops by one thread do not change another thread's entries.
- R12: Lookups with `lk_valid` = 0, or of class plain (0) or conditional (1), neither push nor pop. `ret_valid` is asserted only for a valid return lookup.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_pc | input | PC_W | PC of the looked-up instruction |
| lk_tid | input | TID_W | Thread issuing the lookup |
| lk_class | input | 2 | 0 plain, 1 conditional, 2 call/link, 3 register return |
| up_valid | input | 1 | Resolved conditional branch present |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Actual direction of the resolved branch |
| pred_taken | output | 1 | Predicted direction for a conditional lookup |
| ret_valid | output | 1 | Return target prediction is valid |
| ret_target | output | PC_W | Predicted return address |

## Verification
The bench uses the default parameters: a 32-bit PC, a 9-bit index starting at bit 3, four threads and a stack depth of four, with same-cycle forwarding enabled. With these values, PCs 4 KB apart alias onto one counter, which makes the index slice observable from both sides. The fifth push on one thread reaches the overwrite case. The highest thread id, 3, is exercised. Concurrent update and lookup of one entry exposes whether the forwarding path is present.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

   typedef enum logic [1:0] {
      CLS_PLAIN = 2'd0,
      CLS_COND  = 2'd1,
      CLS_CALL  = 2'd2,
      CLS_RET   = 2'd3
   } instr_cls_e;

   localparam logic [1:0] CTR_WEAK_NT = 2'b01;

   // Saturating two-bit step toward the observed direction
   function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic taken);
      if (taken) return (c == 2'b11) ? c : c + 2'b01;
      else       return (c == 2'b00) ? c : c - 2'b01;
   endfunction

endpackage

// File: rtl/bpred_dir_table.sv
module bpred_dir_table
   import bpred_pkg::*;
#(
   parameter int         IDX_W     = 9,
   parameter logic [1:0] RESET_CTR = CTR_WEAK_NT,
   parameter bit         FORWARD   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_taken,
   output logic [1:0]       rd_ctr
);
   localparam int ENTRIES = 1 << IDX_W;

   if (IDX_W < 1 || IDX_W > 12) begin : g_bad_idx
      $error("bpred_dir_table: IDX_W out of range");
   end

   logic [1:0] ctr_q [ENTRIES];
   logic [1:0] wr_new;

   always_comb wr_new = ctr_step(ctr_q[wr_idx], wr_taken);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= RESET_CTR;
      end else if (wr_en) begin
         ctr_q[wr_idx] <= wr_new;
      end
   end

   if (FORWARD) begin : g_fwd
      always_comb rd_ctr = (wr_en && (wr_idx == rd_idx)) ? wr_new : ctr_q[rd_idx];
   end else begin : g_nofwd
      always_comb rd_ctr = ctr_q[rd_idx];
   end

endmodule

// File: rtl/bpred_ret_stack.sv
module bpred_ret_stack #(
   parameter int PC_W  = 32,
   parameter int DEPTH = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            push,
   input  logic            pop,
   input  logic [PC_W-1:0] push_addr,
   output logic            top_valid,
   output logic [PC_W-1:0] top_addr
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

   if (DEPTH < 2 || (1 << PTR_W) != DEPTH) begin : g_bad_depth
      $error("bpred_ret_stack: DEPTH must be a power of two, at least 2");
   end

   logic [PC_W-1:0]  slot_q [DEPTH];
   logic [PTR_W-1:0] wptr_q;
   logic [CNT_W-1:0] cnt_q;
   logic [PTR_W-1:0] top_ptr;

   assign top_ptr   = wptr_q - 1'b1;
   assign top_valid = (cnt_q != '0);
   assign top_addr  = slot_q[top_ptr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr_q <= '0;
         cnt_q  <= '0;
         for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
      end else if (push) begin
         slot_q[wptr_q] <= push_addr;
         wptr_q         <= wptr_q + 1'b1;
         if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
      end else if (pop && top_valid) begin
         wptr_q <= top_ptr;
         cnt_q  <= cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/bpred_top.sv
module bpred_top
   import bpred_pkg::*;
#(
   parameter int PC_W      = 32,
   parameter int IDX_W     = 9,
   parameter int IDX_LSB   = 3,
   parameter int NTHREAD   = 4,
   parameter int RAS_DEPTH = 4,
   parameter int LINK_OFS  = 8,
   parameter bit FORWARD   = 1'b1,
   localparam int TID_W    = (NTHREAD > 1) ? $clog2(NTHREAD) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lk_valid,
   input  logic [PC_W-1:0]  lk_pc,
   input  logic [TID_W-1:0] lk_tid,
   input  logic [1:0]       lk_class,
   input  logic             up_valid,
   input  logic [PC_W-1:0]  up_pc,
   input  logic             up_taken,
   output logic             pred_taken,
   output logic             ret_valid,
   output logic [PC_W-1:0]  ret_target
);
   if (IDX_LSB + IDX_W > PC_W) begin : g_bad_slice
      $error("bpred_top: index slice exceeds PC width");
   end

   instr_cls_e       cls;
   logic [IDX_W-1:0] lk_idx, up_idx;
   logic [1:0]       sel_ctr;
   logic [PC_W-1:0]  link_addr;
   logic             thr_valid [NTHREAD];
   logic [PC_W-1:0]  thr_addr  [NTHREAD];
   logic             sel_valid;
   logic [PC_W-1:0]  sel_addr;

   assign cls       = instr_cls_e'(lk_class);
   assign lk_idx    = lk_pc[IDX_LSB +: IDX_W];
   assign up_idx    = up_pc[IDX_LSB +: IDX_W];
   assign link_addr = lk_pc + PC_W'(LINK_OFS);

   bpred_dir_table #(
      .IDX_W     (IDX_W),
      .RESET_CTR (CTR_WEAK_NT),
      .FORWARD   (FORWARD)
   ) u_dir (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (lk_idx),
      .wr_en    (up_valid),
      .wr_idx   (up_idx),
      .wr_taken (up_taken),
      .rd_ctr   (sel_ctr)
   );

   for (genvar t = 0; t < NTHREAD; t++) begin : g_thr
      logic mine;
      assign mine = lk_valid && (lk_tid == TID_W'(t));
      bpred_ret_stack #(
         .PC_W  (PC_W),
         .DEPTH (RAS_DEPTH)
      ) u_ras (
         .clk       (clk),
         .rst_n     (rst_n),
         .push      (mine && (cls == CLS_CALL)),
         .pop       (mine && (cls == CLS_RET)),
         .push_addr (link_addr),
         .top_valid (thr_valid[t]),
         .top_addr  (thr_addr[t])
      );
   end

   always_comb begin
      sel_valid = 1'b0;
      sel_addr  = '0;
      for (int t = 0; t < NTHREAD; t++) begin
         if (lk_tid == TID_W'(t)) begin
            sel_valid = thr_valid[t];
            sel_addr  = thr_addr[t];
         end
      end
   end

   assign pred_taken = lk_valid && (cls == CLS_COND) && sel_ctr[1];
   assign ret_valid  = lk_valid && (cls == CLS_RET) && sel_valid;
   assign ret_target = sel_addr;

endmodule

// File: rtl/bpred_chk.sv
module bpred_chk #(
   parameter int PC_W     = 32,
   parameter int IDX_W    = 9,
   parameter int IDX_LSB  = 3,
   parameter int TID_W    = 2,
   parameter int LINK_OFS = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lk_valid,
   input logic [PC_W-1:0]  lk_pc,
   input logic [TID_W-1:0] lk_tid,
   input logic [1:0]       lk_class,
   input logic             up_valid,
   input logic [PC_W-1:0]  up_pc,
   input logic             up_taken,
   input logic             pred_taken,
   input logic             ret_valid,
   input logic [PC_W-1:0]  ret_target
);
   logic             call_q;
   logic [TID_W-1:0] call_tid_q;
   logic [PC_W-1:0]  call_link_q;
   logic             ut_q, twice_q;
   logic [IDX_W-1:0] ut_idx_q, twice_idx_q;
   logic [IDX_W-1:0] lk_idx, up_idx;

   assign lk_idx = lk_pc[IDX_LSB +: IDX_W];
   assign up_idx = up_pc[IDX_LSB +: IDX_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         call_q      <= 1'b0;
         call_tid_q  <= '0;
         call_link_q <= '0;
         ut_q        <= 1'b0;
         ut_idx_q    <= '0;
         twice_q     <= 1'b0;
         twice_idx_q <= '0;
      end else begin
         call_q      <= lk_valid && (lk_class == 2'd2);
         call_tid_q  <= lk_tid;
         call_link_q <= lk_pc + PC_W'(LINK_OFS);
         ut_q        <= up_valid && up_taken;
         ut_idx_q    <= up_idx;
         twice_q     <= ut_q && up_valid && up_taken && (up_idx == ut_idx_q);
         twice_idx_q <= up_idx;
      end
   end

   // R7
   push_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (call_q && lk_valid && (lk_class == 2'd3) && (lk_tid == call_tid_q))
      |-> (ret_valid && (ret_target == call_link_q)));

   // R12
   ret_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ret_valid |-> (lk_valid && (lk_class == 2'd3)));

   // R2
   pred_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pred_taken |-> (lk_valid && (lk_class == 2'd1)));

   // R3
   two_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (twice_q && lk_valid && (lk_class == 2'd1) && (lk_idx == twice_idx_q)
       && !(up_valid && !up_taken && (up_idx == lk_idx)))
      |-> pred_taken);

endmodule

bind bpred_top bpred_chk #(
   .PC_W     (PC_W),
   .IDX_W    (IDX_W),
   .IDX_LSB  (IDX_LSB),
   .TID_W    (TID_W),
   .LINK_OFS (LINK_OFS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .lk_valid   (lk_valid),
   .lk_pc      (lk_pc),
   .lk_tid     (lk_tid),
   .lk_class   (lk_class),
   .up_valid   (up_valid),
   .up_pc      (up_pc),
   .up_taken   (up_taken),
   .pred_taken (pred_taken),
   .ret_valid  (ret_valid),
   .ret_target (ret_target)
);

// File: tb/tb_bpred_top.sv
module tb_bpred_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_pc = '0;
   logic [1:0]  lk_tid = '0;
   logic [1:0]  lk_class = '0;
   logic        up_valid = 1'b0;
   logic [31:0] up_pc = '0;
   logic        up_taken = 1'b0;
   logic        pred_taken, ret_valid;
   logic [31:0] ret_target;

   logic        o_pt, o_rv;
   logic [31:0] o_rt;
   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bpred_top dut (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc),
      .lk_tid(lk_tid), .lk_class(lk_class), .up_valid(up_valid),
      .up_pc(up_pc), .up_taken(up_taken), .pred_taken(pred_taken),
      .ret_valid(ret_valid), .ret_target(ret_target)
   );

   task automatic chk1(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
      end
   endtask

   task automatic chkw(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // One cycle on both ports; outputs sampled before the committing edge
   task automatic cyc(input logic lv, input logic [31:0] pc, input logic [1:0] tid,
                      input logic [1:0] cls, input logic uv, input logic [31:0] upc,
                      input logic ut);
      @(negedge clk);
      lk_valid = lv; lk_pc = pc; lk_tid = tid; lk_class = cls;
      up_valid = uv; up_pc = upc; up_taken = ut;
      #1;
      o_pt = pred_taken; o_rv = ret_valid; o_rt = ret_target;
      @(posedge clk);
      #1;
      lk_valid = 1'b0; up_valid = 1'b0;
   endtask

   task automatic look(input logic [31:0] pc, input logic [1:0] tid);
      cyc(1'b1, pc, tid, 2'd1, 1'b0, 32'h0, 1'b0);
   endtask
   task automatic upd(input logic [31:0] pc, input logic tk);
      cyc(1'b0, 32'h0, 2'd0, 2'd0, 1'b1, pc, tk);
   endtask
   task automatic call(input logic [1:0] tid, input logic [31:0] pc);
      cyc(1'b1, pc, tid, 2'd2, 1'b0, 32'h0, 1'b0);
   endtask
   task automatic ret(input logic [1:0] tid);
      cyc(1'b1, 32'h0, tid, 2'd3, 1'b0, 32'h0, 1'b0);
   endtask

   task automatic t_reset();
      look(32'h0000_0100, 2'd0);
      chk1("R1", "pred after reset", o_pt, 1'b0);
      ret(2'd0);
      chk1("R10", "ret_valid empty after reset", o_rv, 1'b0);
   endtask

   task automatic t_counter();
      upd(32'h0000_0100, 1'b1);
      look(32'h0000_0100, 2'd0);
      chk1("R1", "pred after one taken", o_pt, 1'b1);
      upd(32'h0000_0100, 1'b0);
      look(32'h0000_0100, 2'd0);
      chk1("R2", "pred after decrement", o_pt, 1'b0);
      upd(32'h0000_0100, 1'b1);
      cyc(1'b1, 32'h0000_0100, 2'd0, 2'd0, 1'b0, 32'h0, 1'b0);
      chk1("R2", "pred gated for plain class", o_pt, 1'b0);
   endtask

   task automatic t_saturate();
      for (int i = 0; i < 5; i++) upd(32'h0000_0200, 1'b1);
      upd(32'h0000_0200, 1'b0);
      look(32'h0000_0200, 2'd0);
      chk1("R3", "strong taken after one miss", o_pt, 1'b1);
      for (int i = 0; i < 5; i++) upd(32'h0000_0200, 1'b0);
      upd(32'h0000_0200, 1'b1);
      look(32'h0000_0200, 2'd0);
      chk1("R3", "strong not-taken after one hit", o_pt, 1'b0);
   endtask

   task automatic t_index();
      upd(32'h0000_0040, 1'b1);
      look(32'h0000_1040, 2'd0);
      chk1("R4", "alias via bit 12", o_pt, 1'b1);
      look(32'h0000_0044, 2'd0);
      chk1("R4", "alias via bit 2", o_pt, 1'b1);
      look(32'h0000_0048, 2'd0);
      chk1("R4", "neighbour entry untouched", o_pt, 1'b0);
   endtask

   task automatic t_forward();
      cyc(1'b1, 32'h0000_0300, 2'd1, 2'd1, 1'b1, 32'h0000_0300, 1'b1);
      chk1("R5", "same-cycle update forwarded", o_pt, 1'b1);
      cyc(1'b1, 32'h0000_0310, 2'd1, 2'd1, 1'b1, 32'h0000_0308, 1'b1);
      chk1("R5", "other-entry update not forwarded", o_pt, 1'b0);
      look(32'h0000_0300, 2'd2);
      chk1("R5", "forwarded update committed", o_pt, 1'b1);
   endtask

   task automatic t_shared();
      upd(32'h0000_0400, 1'b1);
      look(32'h0000_0400, 2'd3);
      chk1("R6", "thread 3 sees shared entry", o_pt, 1'b1);
      look(32'h0000_0400, 2'd0);
      chk1("R6", "thread 0 sees shared entry", o_pt, 1'b1);
   endtask

   task automatic t_ras_basic();
      call(2'd1, 32'h0000_1000);
      ret(2'd1);
      chk1("R7", "ret_valid after call", o_rv, 1'b1);
      chkw("R7", "return target", o_rt, 32'h0000_1008);
      ret(2'd1);
      chk1("R10", "empty after pop", o_rv, 1'b0);
   endtask

   task automatic t_ras_order();
      call(2'd2, 32'h0000_2000);
      call(2'd2, 32'h0000_2100);
      call(2'd2, 32'h0000_2200);
      ret(2'd2); chkw("R8", "lifo pop 1", o_rt, 32'h0000_2208);
      ret(2'd2); chkw("R8", "lifo pop 2", o_rt, 32'h0000_2108);
      ret(2'd2); chkw("R8", "lifo pop 3", o_rt, 32'h0000_2008);
      chk1("R8", "valid on pop 3", o_rv, 1'b1);
      ret(2'd2); chk1("R10", "pop past bottom", o_rv, 1'b0);
   endtask

   task automatic t_overflow();
      for (int i = 0; i < 5; i++) call(2'd3, 32'h0000_3000 + 32'(i) * 32'h100);
      for (int i = 4; i >= 1; i--) begin
         ret(2'd3);
         chk1("R9", "valid after overflow", o_rv, 1'b1);
         chkw("R9", "overflow order", o_rt, 32'h0000_3008 + 32'(i) * 32'h100);
      end
      ret(2'd3);
      chk1("R9", "oldest entry overwritten", o_rv, 1'b0);
   endtask

   task automatic t_threads();
      call(2'd0, 32'h0000_4000);
      call(2'd1, 32'h0000_5000);
      ret(2'd0);
      chkw("R11", "thread 0 own target", o_rt, 32'h0000_4008);
      ret(2'd1);
      chkw("R11", "thread 1 own target", o_rt, 32'h0000_5008);
      chk1("R11", "thread 1 valid", o_rv, 1'b1);
   endtask

   task automatic t_ignored();
      call(2'd0, 32'h0000_6000);
      cyc(1'b0, 32'h0000_7000, 2'd0, 2'd3, 1'b0, 32'h0, 1'b0);
      chk1("R12", "ret_valid with lk_valid low", o_rv, 1'b0);
      cyc(1'b0, 32'h0000_7000, 2'd0, 2'd2, 1'b0, 32'h0, 1'b0);
      look(32'h0000_7100, 2'd0);
      cyc(1'b1, 32'h0000_7200, 2'd0, 2'd0, 1'b0, 32'h0, 1'b0);
      chk1("R12", "ret_valid for plain class", o_rv, 1'b0);
      ret(2'd0);
      chkw("R12", "stack untouched target", o_rt, 32'h0000_6008);
      chk1("R12", "stack untouched valid", o_rv, 1'b1);
      ret(2'd0);
      chk1("R12", "no extra entries pushed", o_rv, 1'b0);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_counter();
      t_saturate();
      t_index();
      t_forward();
      t_shared();
      t_ras_basic();
      t_ras_order();
      t_overflow();
      t_threads();
      t_ignored();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule